// File: doc/BRIEF.md
# Event and Interrupt Line Router

This block sits between the channel threads of a DMA controller and the rest of the chip. A channel thread signals an event by number. For every line a bit in the enable register decides what that signal turns into. With the bit set, the signal raises a sticky interrupt output toward the CPU, and that output stays high until software clears it. With the bit clear, the signal becomes an internal event that wakes every channel waiting on that number.

An internal event that arrives while no channel is waiting is not lost. It is held in a per-line pending flag. The next channel that begins a wait on that line completes its wait immediately and uses up the flag. Software sees the lines through four word registers: enable, raw status, interrupt status and a write-one-to-clear register. Channel state and instruction execution are kept outside the block. The block only receives a per-line "some channel is waiting" level and a per-line "a wait begins now" pulse, and it returns a per-line wake pulse.

Top module: `evt_irq_router`

## Requirements
- R1: A signal on line N (`sig_valid` high, `sig_num` = N) while enable bit N is 1 sets `irq_o[N]` at the next clock edge. The output stays high through idle cycles.
- R2: A write to register 3 (clear) with bit N set drops `irq_o[N]` at the next edge. Lines whose bit is 0 in that write keep their state.
- R3: A write to register 0 (enable) with bit N equal to 0 drops `irq_o[N]` at the next edge.
- R4: A signal on line N while enable bit N is 0 gives a one-cycle pulse on `wake_o[N]` at the next edge if `chan_waiting[N]` or `wait_arm[N]` is high in the signalling cycle. The pending flag then stays clear and `irq_o[N]` stays low.
- R5: A signal on line N while enable bit N is 0 and no channel waits on N sets the pending flag of line N. The flag shows as bit N of raw status (register 1), and no wake and no interrupt follow.
- R6: A `wait_arm[N]` pulse while the pending flag of N is set gives a `wake_o[N]` pulse at the next edge and clears the flag in that same edge.
- R7: Read data is combinational from `reg_addr`. Register 0 returns the enable bits. Register 1 returns pending flag OR interrupt per line. Register 2 returns the interrupt outputs only. Register 3 reads 0. All bits at and above NUM_LINES read 0.
- R8: A signal whose number is NUM_LINES or above changes no output and no status.
- R9: Reset (synchronous, active low) clears all interrupt outputs, pending flags, wake outputs and enable bits.
- R10: When a clear write and a new enabled signal hit the same line in one cycle, the clear wins and the output is low after the edge.
- R11: `wake_o` pulses only in the cycle after a signal or a wait start. It is 0 after a cycle that has neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_valid | input | 1 | A channel thread signals a line this cycle |
| sig_num | input | 5 | Number of the signalled line |
| chan_waiting | input | NUM_LINES | Per line: at least one channel is parked waiting on it |
| wait_arm | input | NUM_LINES | Per line: a channel begins a wait on it this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 raw status, 2 interrupt status, 3 clear |
| reg_wdata | input | NUM_LINES | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | NUM_LINES | Sticky interrupt outputs |
| wake_o | output | NUM_LINES | One-cycle wake pulses toward the channels |

## Verification
A stuck or lost pending flag shows in two places. It appears on raw status in the cycle after the signal. It also appears as a missing or extra `wake_o` pulse one cycle after the next wait begins. A sticky interrupt bit that fails to hold, or fails to clear, shows on `irq_o` and on register 2 one edge after the causing cycle. Because every state bit reaches a port within one clock, each stimulus step is checked right after its edge. Same-cycle collisions (clear against signal, wait start against signal) are driven on purpose. Those are the cases where a wrong priority would leave a line in the wrong state.

// File: rtl/evt_router_pkg.sv
// Package: shared constants and the register select encoding for the
// event and interrupt router. Assumes a four-word register window.
package evt_router_pkg;
    localparam int MAX_LINES = 32;
    localparam int NUM_W     = 5;
    localparam int RDATA_W   = 32;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_RAW    = 2'd1,
        SEL_IRQ    = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/evt_sig_decode.sv
// Module: turns a numbered signal into a one-hot line vector.
// Assumes NUM_LINES <= 32; numbers at or above NUM_LINES decode to no line.
module evt_sig_decode #(
    parameter int NUM_LINES = 24
) (
    input  logic                                sig_valid,
    input  logic [evt_router_pkg::NUM_W-1:0]    sig_num,
    output logic [NUM_LINES-1:0]                hit
);
    import evt_router_pkg::*;

    // One comparator per line; out-of-range numbers match nothing
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
        assign hit[i] = sig_valid && (sig_num == NUM_W'(i));
    end
endmodule

// File: rtl/evt_cfg_regs.sv
// Module: enable register, write-strobe decode and read mux.
// Assumes single-cycle writes and combinational reads; unused upper read bits are zero.
module evt_cfg_regs #(
    parameter int NUM_LINES = 24
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 reg_wr,
    input  logic [1:0]                           reg_addr,
    input  logic [NUM_LINES-1:0]                 reg_wdata,
    input  logic [NUM_LINES-1:0]                 pend_q,
    input  logic [NUM_LINES-1:0]                 irq_q,
    output logic [NUM_LINES-1:0]                 en_q,
    output logic [NUM_LINES-1:0]                 drop_mask,
    output logic [evt_router_pkg::RDATA_W-1:0]   reg_rdata
);
    import evt_router_pkg::*;

    reg_sel_e sel;
    logic     wr_en, wr_clr;

    assign sel    = reg_sel_e'(reg_addr);
    assign wr_en  = reg_wr && (sel == SEL_ENABLE);
    assign wr_clr = reg_wr && (sel == SEL_CLEAR);

    // Hold the per-line enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= reg_wdata;
    end

    // Lines whose interrupt must fall: cleared bits or disabled bits
    always_comb begin
        drop_mask = '0;
        if (wr_clr)
            drop_mask = reg_wdata;
        else if (wr_en)
            drop_mask = ~reg_wdata;
    end

    // Select read data, zero-extended above the configured line count
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_ENABLE: reg_rdata[NUM_LINES-1:0] = en_q;
            SEL_RAW:    reg_rdata[NUM_LINES-1:0] = pend_q | irq_q;
            SEL_IRQ:    reg_rdata[NUM_LINES-1:0] = irq_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_line.sv
// Module: state of one line: sticky interrupt, pending event flag, wake pulse.
// Assumes a channel starting a wait in the same cycle as a signal counts as waiting.
module evt_line (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic en,
    input  logic drop,
    input  logic waiting,
    input  logic arm,
    output logic irq_q,
    output logic pend_q,
    output logic wake_q
);
    logic hit_irq, hit_evt, any_wait;

    assign hit_irq  = hit && en;
    assign hit_evt  = hit && !en;
    assign any_wait = waiting || arm;

    // Sticky interrupt; a drop request outranks a new signal
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (drop)
            irq_q <= 1'b0;
        else if (hit_irq)
            irq_q <= 1'b1;
    end

    // Pending flag: latched only when nobody waits, consumed by a new wait
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (hit_evt)
            pend_q <= !any_wait;
        else if (arm)
            pend_q <= 1'b0;
    end

    // Wake pulse for a signal with waiters or a wait meeting a pending flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_q <= 1'b0;
        else
            wake_q <= (hit_evt && any_wait) || (arm && pend_q);
    end
endmodule

// File: rtl/evt_irq_router.sv
// Module: top of the event and interrupt router.
// Assumes NUM_LINES between 1 and 32 and at most one signal per cycle.
module evt_irq_router #(
    parameter int NUM_LINES = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sig_valid,
    input  logic [4:0]              sig_num,
    input  logic [NUM_LINES-1:0]    chan_waiting,
    input  logic [NUM_LINES-1:0]    wait_arm,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_addr,
    input  logic [NUM_LINES-1:0]    reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic [NUM_LINES-1:0]    irq_o,
    output logic [NUM_LINES-1:0]    wake_o
);
    logic [NUM_LINES-1:0] hit, en_q, drop_mask, pend_q;

    evt_sig_decode #(.NUM_LINES(NUM_LINES)) u_dec (
        .sig_valid (sig_valid),
        .sig_num   (sig_num),
        .hit       (hit)
    );

    evt_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .irq_q     (irq_o),
        .en_q      (en_q),
        .drop_mask (drop_mask),
        .reg_rdata (reg_rdata)
    );

    // One state slice per line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        evt_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit[i]),
            .en      (en_q[i]),
            .drop    (drop_mask[i]),
            .waiting (chan_waiting[i]),
            .arm     (wait_arm[i]),
            .irq_q   (irq_o[i]),
            .pend_q  (pend_q[i]),
            .wake_q  (wake_o[i])
        );
    end
endmodule

// File: rtl/evt_irq_router_chk.sv
// Module: protocol checker bound to the router; observes ports and the enable bits.
// Assumes the same NUM_LINES as the bound instance.
module evt_irq_router_chk #(
    parameter int NUM_LINES = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sig_valid,
    input logic [4:0]           sig_num,
    input logic [NUM_LINES-1:0] chan_waiting,
    input logic [NUM_LINES-1:0] wait_arm,
    input logic                 reg_wr,
    input logic [1:0]           reg_addr,
    input logic [NUM_LINES-1:0] reg_wdata,
    input logic [NUM_LINES-1:0] irq_o,
    input logic [NUM_LINES-1:0] wake_o,
    input logic [NUM_LINES-1:0] en_q
);
    logic was_reset;

    // Remember that the previous edge saw reset asserted
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
    end

    // R9
    always_ff @(posedge clk) begin
        if (rst_n && was_reset)
            reset_clear_chk: assert (irq_o == '0 && wake_o == '0);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        // R1
        irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sig_valid && sig_num == 5'(i) && en_q[i] && !reg_wr) |=> irq_o[i]);
        // R4
        wake_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sig_valid && sig_num == 5'(i) && !en_q[i] && (chan_waiting[i] || wait_arm[i])) |=> (wake_o[i] && !irq_o[i]));
    end

    // R2
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> ((irq_o & $past(reg_wdata)) == '0));
    // R3
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> ((irq_o & ~$past(reg_wdata)) == '0));
    // R8
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sig_valid && sig_num < 5'(NUM_LINES)) |=> ((irq_o & ~$past(irq_o)) == '0));
    // R11
    no_spurious_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_valid && wait_arm == '0) |=> (wake_o == '0));
endmodule

bind evt_irq_router evt_irq_router_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sig_valid    (sig_valid),
    .sig_num      (sig_num),
    .chan_waiting (chan_waiting),
    .wait_arm     (wait_arm),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .irq_o        (irq_o),
    .wake_o       (wake_o),
    .en_q         (en_q)
);

// File: tb/evt_irq_router_test.sv
// Bench: walks a vector table, then runs directed checks for registers and reset.
module evt_irq_router_test;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sig_valid;
    logic [4:0]    sig_num;
    logic [N-1:0]  chan_waiting, wait_arm, reg_wdata;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  irq_o, wake_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    evt_irq_router #(.NUM_LINES(N)) uut (
        .clk, .rst_n, .sig_valid, .sig_num, .chan_waiting, .wait_arm,
        .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq_o, .wake_o
    );

    typedef struct packed {
        logic         sv;
        logic [4:0]   sn;
        logic         wr;
        logic [1:0]   ad;
        logic [23:0]  wd;
        logic [23:0]  wt;
        logic [23:0]  arm;
        logic [23:0]  e_irq;
        logic [23:0]  e_raw;
        logic [23:0]  e_wake;
    } step_t;

    localparam int NSTEP = 16;
    localparam step_t STEPS [0:NSTEP-1] = '{
        '{1'b0, 5'd0,  1'b1, 2'd0, 24'hF,  24'h0,  24'h0,  24'h0, 24'h0,      24'h0},
        '{1'b1, 5'd2,  1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h4, 24'h4,      24'h0},
        '{1'b0, 5'd0,  1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h4, 24'h4,      24'h0},
        '{1'b1, 5'd1,  1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h6, 24'h6,      24'h0},
        '{1'b0, 5'd0,  1'b1, 2'd3, 24'h4,  24'h0,  24'h0,  24'h2, 24'h2,      24'h0},
        '{1'b0, 5'd0,  1'b1, 2'd0, 24'hD,  24'h0,  24'h0,  24'h0, 24'h0,      24'h0},
        '{1'b1, 5'd5,  1'b0, 2'd0, 24'h0,  24'h20, 24'h0,  24'h0, 24'h0,      24'h20},
        '{1'b0, 5'd0,  1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h0, 24'h0,      24'h0},
        '{1'b1, 5'd6,  1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h0, 24'h40,     24'h0},
        '{1'b0, 5'd0,  1'b0, 2'd0, 24'h0,  24'h0,  24'h40, 24'h0, 24'h0,      24'h40},
        '{1'b1, 5'd7,  1'b0, 2'd0, 24'h0,  24'h0,  24'h80, 24'h0, 24'h0,      24'h80},
        '{1'b1, 5'd30, 1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h0, 24'h0,      24'h0},
        '{1'b1, 5'd23, 1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h0, 24'h800000, 24'h0},
        '{1'b1, 5'd0,  1'b1, 2'd3, 24'h1,  24'h0,  24'h0,  24'h0, 24'h800000, 24'h0},
        '{1'b1, 5'd0,  1'b0, 2'd0, 24'h0,  24'h0,  24'h0,  24'h1, 24'h800001, 24'h0},
        '{1'b1, 5'd2,  1'b0, 2'd0, 24'h0,  24'h4,  24'h0,  24'h5, 24'h800005, 24'h0}
    };
    localparam string TAGS [0:NSTEP-1] = '{
        "R3", "R1", "R1", "R1", "R2", "R3", "R4", "R11",
        "R5", "R6", "R4", "R8", "R5", "R10", "R1", "R1"
    };

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Return all stimulus inputs to idle and select raw status for reading
    task automatic idle();
        sig_valid    = 1'b0;
        sig_num      = '0;
        chan_waiting = '0;
        wait_arm     = '0;
        reg_wr       = 1'b0;
        reg_addr     = 2'd1;
        reg_wdata    = '0;
    endtask

    // Read one register combinationally between edges
    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        // R9: state after reset
        chk("R9", "irq", 32'(irq_o), 32'h0);
        chk("R9", "wake", 32'(wake_o), 32'h0);
        rd(2'd1, v); chk("R9", "raw", v, 32'h0);
        rd(2'd0, v); chk("R9", "enable", v, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            sig_valid    = STEPS[i].sv;
            sig_num      = STEPS[i].sn;
            reg_wr       = STEPS[i].wr;
            reg_addr     = STEPS[i].ad;
            reg_wdata    = STEPS[i].wd;
            chan_waiting = STEPS[i].wt;
            wait_arm     = STEPS[i].arm;
            @(posedge clk);
            #5;
            idle();
            #1;
            chk(TAGS[i], $sformatf("step %0d irq", i), 32'(irq_o), 32'(STEPS[i].e_irq));
            chk(TAGS[i], $sformatf("step %0d wake", i), 32'(wake_o), 32'(STEPS[i].e_wake));
            chk(TAGS[i], $sformatf("step %0d raw", i), reg_rdata, 32'(STEPS[i].e_raw));
        end

        // R7: register views
        rd(2'd0, v); chk("R7", "enable read", v, 32'hD);
        rd(2'd2, v); chk("R7", "irq status read", v, 32'h5);
        rd(2'd3, v); chk("R7", "clear read", v, 32'h0);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = '1;
        @(posedge clk);
        #5;
        idle();
        rd(2'd0, v); chk("R7", "enable upper bits", v, 32'h00FF_FFFF);
        chk("R3", "all-ones enable keeps irq", 32'(irq_o), 32'h5);

        // R9: reset mid-run clears everything
        sig_valid = 1'b1; sig_num = 5'd9;
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        idle();
        rst_n = 1'b1;
        #1;
        chk("R9", "irq after reset", 32'(irq_o), 32'h0);
        rd(2'd1, v); chk("R9", "raw after reset", v, 32'h0);
        rd(2'd0, v); chk("R9", "enable after reset", v, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule